// File: doc/BRIEF.md
# Auto-Aligning Memory-to-Display DMA Channel

This block is a single DMA channel that streams pixel data from byte-addressed memory into one fixed 16-bit display data port. Software programs a source address and a byte count, then writes a control word with the start bit set. The channel splits the job into aligned reads. A single halfword read brings the address onto a 4-byte boundary. Longword reads follow until the address reaches a 16-byte boundary. Four-beat line bursts run while a whole line remains. Longwords take what is left, and a lone halfword closes the transfer.

Every 32-bit word fetched leaves through the port as two 16-bit writes, upper half first. After each port write the channel holds back for a programmable number of wait cycles. When the last write has drained, a sticky done flag sets, and software clears it by writing 1. A rectangular screen update is issued as one transfer per row, each starting at the row base plus the row pitch.

Top module: `dma_align_chan`

## Requirements
- R1: Register offsets on `reg_addr` are 0 = source address, 1 = byte count, 2 = control, 3 = status. The status register reads bit 0 = done and bit 1 = busy, and reads 0 after reset. Control bit 16 is the start bit and reads back as 0. Every other control bit is stored and reads back as written: bit 30 request enable, bit 29 cycle steal, bit 28 align enable, bits 27:25 bandwidth, bit 22 source increment, bits 21:20 source size, bit 19 destination increment, and bits 3:0 the wait-state count.
- R2: Port writes carry the source halfwords in ascending address order. A longword read at address A returns the halfword at A in bits 31:16 and the halfword at A+2 in bits 15:0, and the port receives bits 31:16 first. A halfword read returns its data in bits 15:0.
- R3: Status bit 0 sets once the last port write of a transfer has completed. Writing 1 to status bit 0 clears it.
- R4: A halfword read (`mem_kind` 0) is issued only when address bit 1 is set or exactly 2 bytes remain. A longword read (`mem_kind` 1) is always 4-byte aligned.
- R5: A line read (`mem_kind` 3, four beats at A, A+4, A+8, A+12) is issued exactly when the address is 16-byte aligned and at least 16 bytes remain.
- R6: A remainder shorter than 16 bytes at a 4-byte-aligned address is moved as longwords, followed by at most one final halfword.
- R7: Within a transfer, two consecutive port writes are at least (wait-state count + 1) clock cycles apart. Wait-state counts 0 to 15 are supported.
- R8: A byte count of zero, or an odd byte count, sets done with no memory read and no port write.
- R9: Writes to offsets 0 to 2 while the channel is busy leave the registers unchanged and do not disturb the running transfer.
- R10: Back-to-back transfers with new source addresses, as used for row-by-row rectangle updates, each deliver exactly their own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_kind | output | 2 | 0 halfword, 1 longword, 3 four-beat line |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rdata | input | 32 | Read data beat |
| port_we | output | 1 | Display port write strobe |
| port_data | output | 16 | Display port write data |

## Verification
The assertions assume that memory answers each request with exactly one beat for a halfword or longword and four beats for a line, in address order, before the channel can issue another request. They also assume the wait-state field changes only while the channel is idle, which the block enforces by ignoring control writes during a transfer. The bench memory model returns beats starting one cycle after each request and computes every halfword from its address. Any misordered or misaligned read therefore shows up as wrong port data. The stimulus tallies the read kinds per transfer and compares them with counts worked out by hand.

// File: rtl/dma_align_pkg.sv
package dma_align_pkg;
  typedef enum logic [1:0] {
    RK_HALF = 2'd0,
    RK_LONG = 2'd1,
    RK_LINE = 2'd3
  } rd_kind_e;

  localparam int unsigned OFS_SRC   = 0;
  localparam int unsigned OFS_LEN   = 1;
  localparam int unsigned OFS_CTL   = 2;
  localparam int unsigned OFS_STAT  = 3;
  localparam int unsigned CTL_START = 16;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_align_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned WS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              done_set,
  output logic [ADDR_W-1:0] src_addr,
  output logic [LEN_W-1:0]  byte_len,
  output logic [WS_W-1:0]   wait_states,
  output logic              start,
  output logic              done
);
  logic [ADDR_W-1:0] src_q, src_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [31:0]       ctl_q, ctl_d;
  logic              start_q, start_d, done_q, done_d;
  logic              wr_cfg;

  assign wr_cfg = reg_wr && !busy;

  always_comb begin
    src_d   = src_q;
    len_d   = len_q;
    ctl_d   = ctl_q;
    start_d = 1'b0;
    if (wr_cfg && reg_addr == 2'(OFS_SRC)) src_d = reg_wdata[ADDR_W-1:0];
    if (wr_cfg && reg_addr == 2'(OFS_LEN)) len_d = reg_wdata[LEN_W-1:0];
    if (wr_cfg && reg_addr == 2'(OFS_CTL)) begin
      ctl_d   = reg_wdata & ~(32'd1 << CTL_START);
      start_d = reg_wdata[CTL_START];
    end
    if (done_set) done_d = 1'b1;
    else if (reg_wr && reg_addr == 2'(OFS_STAT) && reg_wdata[0]) done_d = 1'b0;
    else done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      len_q   <= '0;
      ctl_q   <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      src_q   <= src_d;
      len_q   <= len_d;
      ctl_q   <= ctl_d;
      start_q <= start_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    case (reg_addr)
      2'(OFS_SRC): reg_rdata = 32'(src_q);
      2'(OFS_LEN): reg_rdata = 32'(len_q);
      2'(OFS_CTL): reg_rdata = ctl_q;
      default:     reg_rdata = {30'd0, busy, done_q};
    endcase
  end

  assign src_addr    = src_q;
  assign byte_len    = len_q;
  assign wait_states = ctl_q[WS_W-1:0];
  assign start       = start_q;
  assign done        = done_q;
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_align_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [LEN_W-1:0]  byte_len,
  output logic              busy,
  output logic              done_set,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output rd_kind_e          mem_kind,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              hw_valid,
  output logic [15:0]       hw_data,
  input  logic              hw_ready,
  input  logic              port_idle
);
  localparam int unsigned LINE_BYTES = LINE_WORDS * 4;
  localparam int unsigned BEAT_W     = $clog2(LINE_WORDS);
  localparam int unsigned HW_W       = $clog2(LINE_WORDS * 2);

  typedef enum logic [2:0] {S_IDLE, S_PICK, S_REQ, S_FILL, S_EMIT, S_DRAIN} st_e;

  st_e                 st_q, st_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [LEN_W-1:0]    rem_q, rem_d;
  rd_kind_e            kind_q, kind_d, pick;
  logic [BEAT_W-1:0]   beat_q, beat_d;
  logic [HW_W-1:0]     hidx_q, hidx_d, last_hidx;
  logic [LEN_W-1:0]    step;
  logic [31:0]         buf_q [LINE_WORDS];
  logic [LINE_WORDS-1:0] buf_we;
  logic [31:0]         word_sel;
  logic                len_ok, line_al;

  assign len_ok  = (byte_len != '0) && !byte_len[0];
  assign line_al = (addr_q & ADDR_W'(LINE_BYTES - 1)) == '0;

  always_comb begin
    if (addr_q[1] || rem_q < LEN_W'(4))                pick = RK_HALF;
    else if (line_al && rem_q >= LEN_W'(LINE_BYTES))    pick = RK_LINE;
    else                                                pick = RK_LONG;
    case (kind_q)
      RK_HALF: step = LEN_W'(2);
      RK_LONG: step = LEN_W'(4);
      default: step = LEN_W'(LINE_BYTES);
    endcase
    last_hidx = HW_W'((step >> 1) - 1);
  end

  always_comb begin
    st_d     = st_q;
    addr_d   = addr_q;
    rem_d    = rem_q;
    kind_d   = kind_q;
    beat_d   = beat_q;
    hidx_d   = hidx_q;
    done_set = 1'b0;
    mem_req  = 1'b0;
    hw_valid = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        if (len_ok) begin
          addr_d = {src_addr[ADDR_W-1:1], 1'b0};
          rem_d  = byte_len;
          st_d   = S_PICK;
        end else begin
          done_set = 1'b1;
        end
      end
      S_PICK: if (rem_q == '0) st_d = S_DRAIN;
              else begin kind_d = pick; st_d = S_REQ; end
      S_REQ: begin
        mem_req = 1'b1;
        beat_d  = '0;
        st_d    = S_FILL;
      end
      S_FILL: if (mem_rvalid) begin
        beat_d = beat_q + 1'b1;
        if (kind_q != RK_LINE || beat_q == BEAT_W'(LINE_WORDS - 1)) begin
          hidx_d = '0;
          st_d   = S_EMIT;
        end
      end
      S_EMIT: begin
        hw_valid = 1'b1;
        if (hw_ready) begin
          if (hidx_q == last_hidx) begin
            addr_d = addr_q + ADDR_W'(step);
            rem_d  = rem_q - step;
            st_d   = S_PICK;
          end else begin
            hidx_d = hidx_q + 1'b1;
          end
        end
      end
      S_DRAIN: if (port_idle) begin
        done_set = 1'b1;
        st_d     = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_bwe
    assign buf_we[g] = (st_q == S_FILL) && mem_rvalid && (beat_q == BEAT_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      kind_q <= RK_HALF;
      beat_q <= '0;
      hidx_q <= '0;
      for (int i = 0; i < LINE_WORDS; i++) buf_q[i] <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
      kind_q <= kind_d;
      beat_q <= beat_d;
      hidx_q <= hidx_d;
      for (int i = 0; i < LINE_WORDS; i++)
        if (buf_we[i]) buf_q[i] <= mem_rdata;
    end
  end

  assign word_sel = buf_q[hidx_q[HW_W-1:1]];
  assign hw_data  = (kind_q == RK_HALF) ? buf_q[0][15:0]
                  : (hidx_q[0] ? word_sel[15:0] : word_sel[31:16]);
  assign mem_addr = addr_q;
  assign mem_kind = kind_q;
  assign busy     = st_q != S_IDLE;
endmodule

// File: rtl/dma_port_out.sv
module dma_port_out #(
  parameter int unsigned WS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_valid,
  input  logic [15:0]     hw_data,
  input  logic [WS_W-1:0] wait_states,
  output logic            hw_ready,
  output logic            port_we,
  output logic [15:0]     port_data,
  output logic            idle
);
  logic [WS_W-1:0] cnt_q, cnt_d;
  logic            we_q, we_d, accept;
  logic [15:0]     data_q, data_d;

  assign hw_ready = cnt_q == '0;
  assign accept   = hw_valid && hw_ready;

  always_comb begin
    we_d   = accept;
    data_d = accept ? hw_data : data_q;
    if (accept)             cnt_d = wait_states;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      we_q   <= 1'b0;
      data_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      we_q   <= we_d;
      data_q <= data_d;
    end
  end

  assign port_we   = we_q;
  assign port_data = data_q;
  assign idle      = (cnt_q == '0) && !we_q;
endmodule

// File: rtl/dma_align_chan.sv
module dma_align_chan
  import dma_align_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned WS_W       = 4,
  parameter int unsigned LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_kind,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              port_we,
  output logic [15:0]       port_data
);
  logic [1:0]        rst_sync_q;
  logic              rst_s;
  logic              start, done, done_set, seq_busy, busy_all;
  logic [ADDR_W-1:0] src_addr;
  logic [LEN_W-1:0]  byte_len;
  logic [WS_W-1:0]   wait_states;
  logic              hw_valid, hw_ready, port_idle;
  logic [15:0]       hw_data;
  rd_kind_e          kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  assign busy_all = seq_busy || start;
  assign mem_kind = kind;

  dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WS_W(WS_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy_all),
    .done_set(done_set), .src_addr(src_addr), .byte_len(byte_len),
    .wait_states(wait_states), .start(start), .done(done)
  );

  dma_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_WORDS(LINE_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_s), .start(start), .src_addr(src_addr),
    .byte_len(byte_len), .busy(seq_busy), .done_set(done_set),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_kind(kind),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .hw_valid(hw_valid),
    .hw_data(hw_data), .hw_ready(hw_ready), .port_idle(port_idle)
  );

  dma_port_out #(.WS_W(WS_W)) u_port (
    .clk(clk), .rst_n(rst_s), .hw_valid(hw_valid), .hw_data(hw_data),
    .wait_states(wait_states), .hw_ready(hw_ready), .port_we(port_we),
    .port_data(port_data), .idle(port_idle)
  );
endmodule

module dma_align_chan_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WS_W   = 4
) (
  input logic              clk,
  input logic              rst_s,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              done,
  input logic              done_set,
  input logic              busy_all,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mem_kind,
  input logic              port_we,
  input logic [WS_W-1:0]   wait_states,
  input logic [ADDR_W-1:0] src_addr
);
  logic [WS_W:0] since_q;
  logic          armed_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      since_q <= '0;
      armed_q <= 1'b0;
    end else begin
      if (port_we)                 since_q <= '0;
      else if (since_q != '1)      since_q <= since_q + 1'b1;
      if (!busy_all)               armed_q <= 1'b0;
      else if (port_we)            armed_q <= 1'b1;
    end
  end

  a_r7_wait_gap: assert property (@(posedge clk) disable iff (!rst_s)
    (armed_q && port_we) |-> (since_q >= (WS_W+1)'(wait_states)));

  a_r5_line_aligned: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_req && mem_kind == 2'd3) |-> (mem_addr[3:0] == 4'd0));

  a_r4_long_aligned: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_req && mem_kind == 2'd1) |-> (mem_addr[1:0] == 2'd0));

  a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_s)
    !busy_all |-> (!port_we && !mem_req));

  a_r3_clear_on_one: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_wr && reg_addr == 2'd3 && reg_wdata[0] && !done_set) |=> !done);

  a_r3_set_on_finish: assert property (@(posedge clk) disable iff (!rst_s)
    done_set |=> done);

  a_r9_src_locked: assert property (@(posedge clk) disable iff (!rst_s)
    (busy_all && reg_wr && reg_addr == 2'd0) |=> $stable(src_addr));
endmodule

bind dma_align_chan dma_align_chan_chk #(.ADDR_W(ADDR_W), .WS_W(WS_W)) u_chk (
  .clk(clk), .rst_s(rst_s), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .done(done), .done_set(done_set),
  .busy_all(busy_all), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_kind(mem_kind), .port_we(port_we), .wait_states(wait_states),
  .src_addr(src_addr)
);

// File: tb/dma_align_chan_bench.sv
module dma_align_chan_bench;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [1:0]  mem_kind;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        port_we;
  logic [15:0] port_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // memory responder state (written only by responder)
  int r_left = 0;
  int r_addr = 0;
  int r_kind = 0;
  int n_half = 0, n_long = 0, n_line = 0;
  // port capture (written only by capture block)
  int cap_n = 0, cap_bad = 0, gap_bad = 0, last_cyc = 0;
  // set only by the stimulus
  int exp_base = 0, x_start_n = 0, cur_ws = 0;

  // {src16, len16, ws8, lines8, halves8, longs8}
  localparam int NVEC = 7;
  localparam logic [63:0] VEC [NVEC] = '{
    64'h0100_0020_00_02_00_00,
    64'h0102_0028_04_01_02_05,
    64'h0104_0024_05_01_00_05,
    64'h010E_0006_04_00_01_01,
    64'h0200_0002_07_00_01_00,
    64'h0206_0042_0F_03_01_04,
    64'h0300_00A0_04_0A_00_00
  };

  dma_align_chan u_dma_align_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_kind(mem_kind), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .port_we(port_we), .port_data(port_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] hv(input int a);
    return 16'(a * 7 + 32'h1357);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d cycles exp=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (r_left > 0) begin
      mem_rvalid = 1'b1;
      mem_rdata  = (r_kind == 0) ? {16'h0, hv(r_addr)} : {hv(r_addr), hv(r_addr + 2)};
      r_addr     = r_addr + 4;
      r_left     = r_left - 1;
    end else begin
      mem_rvalid = 1'b0;
    end
    if (mem_req) begin
      r_addr = int'(mem_addr);
      r_kind = int'(mem_kind);
      r_left = (mem_kind == 2'd3) ? 4 : 1;
      if (mem_kind == 2'd0) n_half = n_half + 1;
      else if (mem_kind == 2'd1) n_long = n_long + 1;
      else n_line = n_line + 1;
    end
  end

  always @(negedge clk) begin
    if (port_we) begin
      if (port_data !== hv(exp_base + 2 * (cap_n - x_start_n))) cap_bad = cap_bad + 1;
      if (cap_n > x_start_n && (cyc - last_cyc) < cur_ws + 1) gap_bad = gap_bad + 1;
      last_cyc = cyc;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 2'(a);
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] ctl_of(input int ws);
    return (32'd1 << 28) | (32'd1 << 22) | (32'd3 << 20) | 32'(ws & 15);
  endfunction

  task automatic wait_done(input string tag);
    logic [31:0] s;
    int n;
    n = 0;
    do begin rd(3, s); n++; end while (!s[0] && n < 4000);
    chk(s[1:0] == 2'b01, {tag, " R3 done set, busy low"}, s[1:0], 1);
    wr(3, 32'd1);
    rd(3, s);
    chk(s[1:0] == 2'b00, {tag, " R3 done cleared by write of 1"}, s[1:0], 0);
  endtask

  task automatic launch(input int src, input int len, input int ws);
    @(negedge clk);
    exp_base = src; x_start_n = cap_n; cur_ws = ws;
    wr(0, 32'(src));
    wr(1, 32'(len));
    wr(2, ctl_of(ws) | (32'd1 << 16));
  endtask

  task automatic xfer(input int src, input int len, input int ws,
                      input int elines, input int ehalf, input int elong, input string tag);
    int c0, h0, l0, n0, b0, g0;
    c0 = cap_n; h0 = n_half; l0 = n_long; n0 = n_line; b0 = cap_bad; g0 = gap_bad;
    launch(src, len, ws);
    wait_done(tag);
    chk(cap_n - c0 == len / 2, {tag, " R2 halfword count"}, cap_n - c0, len / 2);
    chk(cap_bad == b0, {tag, " R2 port data order"}, cap_bad - b0, 0);
    chk(gap_bad == g0, {tag, " R7 write spacing"}, gap_bad - g0, 0);
    chk(n_line - n0 == elines, {tag, " R5 line reads"}, n_line - n0, elines);
    chk(n_half - h0 == ehalf, {tag, " R4 halfword reads"}, n_half - h0, ehalf);
    chk(n_long - l0 == elong, {tag, " R6 longword reads"}, n_long - l0, elong);
  endtask

  initial begin
    logic [31:0] v;
    int c0, r0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 32'd0;
    mem_rvalid = 1'b0; mem_rdata = 32'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3, v);
    chk(v == 32'd0, "R1 status after reset", v, 0);
    rd(0, v);
    chk(v == 32'd0, "R1 source after reset", v, 0);
    chk(port_we == 1'b0 && mem_req == 1'b0, "R1 idle outputs after reset", port_we, 0);

    // table of transfers
    for (int i = 0; i < NVEC; i++) begin
      xfer(int'(VEC[i][63:48]), int'(VEC[i][47:32]), int'(VEC[i][31:24]),
           int'(VEC[i][23:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]),
           $sformatf("vec%0d", i));
    end

    // R1 control readback (start bit reads 0, wait field 4 from last vector)
    rd(2, v);
    chk(v == ctl_of(4), "R1 control readback", v, ctl_of(4));

    // R10 rectangle: three rows of 5 pixels, pitch 0x140 bytes
    for (int r = 0; r < 3; r++)
      xfer(32'h400 + r * 32'h140, 10, 4, 0, 1, 2, $sformatf("R10 row%0d", r));

    // R8 zero and odd counts
    c0 = cap_n; r0 = n_half + n_long + n_line;
    launch(32'h500, 0, 4);
    wait_done("R8 zero");
    launch(32'h500, 7, 4);
    wait_done("R8 odd");
    chk(cap_n == c0, "R8 no port writes", cap_n - c0, 0);
    chk(n_half + n_long + n_line == r0, "R8 no memory reads", n_half + n_long + n_line - r0, 0);

    // R9 writes while busy are ignored
    c0 = cap_n;
    launch(32'h300, 160, 4);
    repeat (20) @(negedge clk);
    wr(0, 32'h0000DEAD);
    wr(1, 32'd2);
    wr(2, ctl_of(0) | (32'd1 << 16));
    wait_done("R9");
    rd(0, v);
    chk(v == 32'h300, "R9 source unchanged", v, 32'h300);
    rd(1, v);
    chk(v == 32'd160, "R9 count unchanged", v, 160);
    rd(2, v);
    chk(v == ctl_of(4), "R9 control unchanged", v, ctl_of(4));
    chk(cap_n - c0 == 80, "R9 transfer undisturbed", cap_n - c0, 80);
    chk(cap_bad == 0 && gap_bad == 0, "R9 R2 R7 stream intact", cap_bad + gap_bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule